// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns bytes written by a host into asynchronous serial frames. A one-entry holding buffer accepts a character. When the shift register is idle, the buffer is copied into it on a tick of the 16x baud enable. The character is then sent as a start bit, 5 to 8 data bits, an optional parity bit and 1, 1.5 or 2 stop bits. The frame format is sampled from static configuration inputs at the moment a character is copied into the shift register. A mid-frame change to the configuration therefore affects only the next character.

Four operating modes are selected by `mode_sel`:
- Normal (00).
- Break (01): each loaded character is sent as all-zero line bits.
- Echo (10): the serial output is a direct combinational copy of `rx_pin`, and the buffer is not drained.
- Loop (11): the serial output stays at mark, and the frame appears on `loop_data` so that a receiver can consume it internally.

A low `cts` stops a new character from starting in every mode except loop. A character already in flight always completes.

The sequencer has five states: IDLE, START, DATA, PARITY and STOP. It moves through them as follows:
- IDLE to START on a load. A load needs a tick, a full buffer, a mode other than echo, and `cts` high or loop mode.
- START to DATA after 16 ticks.
- DATA to DATA after every 16 ticks, for each bit except the last.
- DATA to PARITY, or DATA to STOP when parity is off, after the last data bit.
- PARITY to STOP after 16 ticks.
- STOP to IDLE after the stop length.

Top module: `uart_tx_core`

## Requirements
- R1: During and after reset `txd` is 1, `buf_empty` is 1 and `tx_done` is 1, including when reset cuts a frame short.
- R2: A frame starts with a 0 start bit lasting 16 ticks, then data bits least-significant first. `cfg_len` 00/01/10/11 selects 5/6/7/8 data bits, and buffer bits above the length are ignored.
- R3: `cfg_parity` 000, 010 and 100 add an even parity bit after the data. 001, 011 and 101 add an odd parity bit. 110 and 111 send no parity bit.
- R4: The stop interval is 16 ticks when `cfg_stop` is 0. With `cfg_stop` 1 it is 24 ticks for 5-bit characters and 32 ticks for 6 to 8-bit characters.
- R5: `buf_empty` falls on the cycle after a write and rises when the buffer is copied into the shift register. `tx_done` is 1 only when the shift register is idle and the buffer is empty.
- R6: While `cts` is 0 in normal or break mode, no character starts and `txd` stays 1. Dropping `cts` during a character does not shorten it.
- R7: In break mode (`mode_sel` 01) every bit of a loaded frame, stop bits included, is driven as 0 on `txd`.
- R8: In echo mode (`mode_sel` 10) `txd` equals `rx_pin` in the same cycle, and a full buffer stays full.
- R9: In loop mode (`mode_sel` 11) `txd` stays 1. Characters are sent regardless of `cts`, and their frames appear on `loop_data`.
- R10: Outside echo mode, `txd` is 1 whenever no character is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| tick | input | 1 | 16x baud enable, one clock wide |
| cfg_len | input | 2 | Data length code |
| cfg_stop | input | 1 | Long stop select |
| cfg_parity | input | 3 | Parity code |
| mode_sel | input | 2 | Operating mode: 00 normal, 01 break, 10 echo, 11 loop |
| cts | input | 1 | Clear to send, 1 = allowed |
| rx_pin | input | 1 | Receive line, passed through in echo mode |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | DW | Character to send |
| txd | output | 1 | Serial output |
| loop_data | output | 1 | Internal loopback frame, 1 outside loop mode |
| buf_empty | output | 1 | Holding buffer empty |
| tx_done | output | 1 | Shift register idle and buffer empty |

## Verification
The assertions take for granted the following about the inputs:
- `tick` is a single-cycle pulse.
- `mode_sel` never leaves the four listed codes.
- The configuration inputs are only meaningful at the load instant.

The stimulus keeps within these limits:
- It generates ticks from a divider, either on every clock or every third clock.
- It changes configuration only while `tx_done` is high.
- It switches mode only between frames.

The one exception to the last point is the deliberate `cts` drop in the middle of a character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_BREAK  = 2'b01,
        MODE_ECHO   = 2'b10,
        MODE_LOOP   = 2'b11
    } line_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] hold_data,
    output logic          hold_empty
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hold_data  <= '0;
            hold_empty <= 1'b1;
        end else if (wr_en) begin
            // a write in the load cycle refills the buffer after the copy
            hold_data  <= wr_data;
            hold_empty <= 1'b0;
        end else if (take) begin
            hold_empty <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_format.sv
module uart_tx_format #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] raw,
    input  logic [1:0]    len_code,
    input  logic [2:0]    par_code,
    output logic [DW-1:0] masked,
    output logic          par_en,
    output logic          par_bit
);
    // clear every bit at or above the selected character length
    for (genvar g = 0; g < DW; g++) begin : g_mask
        assign masked[g] = raw[g] & (g < (5 + int'(len_code)));
    end

    assign par_en  = !(par_code[2] && par_code[1]);
    // code bit 0 set means odd parity
    assign par_bit = (^masked) ^ par_code[0];
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  line_mode_e    mode,
    input  logic          cts,
    input  logic          rx_pin,
    input  logic          hold_empty,
    input  logic [DW-1:0] data_in,
    input  logic          par_en_in,
    input  logic          par_bit_in,
    input  logic [1:0]    len_in,
    input  logic          stop_in,
    output logic          take,
    output logic          busy,
    output logic          txd,
    output logic          loop_data
);
    localparam int CW   = $clog2(2 * TPB);
    localparam int IW   = $clog2(DW);
    localparam int HALF = TPB / 2;

    tx_state_e      state, state_nx;
    logic [CW-1:0]  cnt, limit, stop_lim;
    logic [IW-1:0]  bidx, last_idx;
    logic [DW-1:0]  shreg;
    logic           par_q, par_on;
    logic           bit_end, frame_bit;

    assign take    = (state == ST_IDLE) && tick && !hold_empty &&
                     (mode != MODE_ECHO) && (cts || mode == MODE_LOOP);
    assign limit   = (state == ST_STOP) ? stop_lim : CW'(TPB - 1);
    assign bit_end = tick && (cnt == limit);
    assign busy    = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take) state_nx = ST_START;
            ST_START:  if (bit_end) state_nx = ST_DATA;
            ST_DATA:   if (bit_end && bidx == last_idx)
                           state_nx = par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_nx = ST_STOP;
            ST_STOP:   if (bit_end) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // frame datapath: format is latched at load
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt      <= '0;
            bidx     <= '0;
            last_idx <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            par_on   <= 1'b0;
            stop_lim <= '0;
        end else if (take) begin
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= data_in;
            last_idx <= IW'(4) + IW'(len_in);
            par_q    <= par_bit_in;
            par_on   <= par_en_in;
            if (!stop_in)           stop_lim <= CW'(TPB - 1);
            else if (len_in == 2'b00) stop_lim <= CW'(TPB + HALF - 1);
            else                    stop_lim <= CW'(2 * TPB - 1);
        end else if (busy && tick) begin
            if (cnt == limit) begin
                cnt <= '0;
                if (state == ST_DATA) begin
                    shreg <= shreg >> 1;
                    bidx  <= bidx + IW'(1);
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        frame_bit = 1'b1;
        unique case (state)
            ST_IDLE:   frame_bit = 1'b1;
            ST_START:  frame_bit = 1'b0;
            ST_DATA:   frame_bit = shreg[0];
            ST_PARITY: frame_bit = par_q;
            ST_STOP:   frame_bit = 1'b1;
            default:   frame_bit = 1'b1;
        endcase

        if (rst)                     txd = 1'b1;
        else if (mode == MODE_ECHO)  txd = rx_pin;
        else if (mode == MODE_LOOP)  txd = 1'b1;
        else if (!busy)              txd = 1'b1;
        else if (mode == MODE_BREAK) txd = 1'b0;
        else                         txd = frame_bit;

        loop_data = (mode == MODE_LOOP) ? frame_bit : 1'b1;
    end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_stop,
    input  logic [2:0]    cfg_parity,
    input  logic [1:0]    mode_sel,
    input  logic          cts,
    input  logic          rx_pin,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          txd,
    output logic          loop_data,
    output logic          buf_empty,
    output logic          tx_done
);
    line_mode_e    line_mode;
    logic [DW-1:0] hold_data, masked;
    logic          take, busy, par_en, par_bit;

    assign line_mode = line_mode_e'(mode_sel);

    uart_tx_hold #(.DW(DW)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .hold_data  (hold_data),
        .hold_empty (buf_empty)
    );

    uart_tx_format #(.DW(DW)) u_fmt (
        .raw      (hold_data),
        .len_code (cfg_len),
        .par_code (cfg_parity),
        .masked   (masked),
        .par_en   (par_en),
        .par_bit  (par_bit)
    );

    uart_tx_seq #(.DW(DW), .TPB(TPB)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .mode       (line_mode),
        .cts        (cts),
        .rx_pin     (rx_pin),
        .hold_empty (buf_empty),
        .data_in    (masked),
        .par_en_in  (par_en),
        .par_bit_in (par_bit),
        .len_in     (cfg_len),
        .stop_in    (cfg_stop),
        .take       (take),
        .busy       (busy),
        .txd        (txd),
        .loop_data  (loop_data)
    );

    assign tx_done = !busy && buf_empty;
endmodule

// File: rtl/uart_tx_core_checker.sv
module uart_tx_core_checker
    import uart_tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input line_mode_e mode,
    input logic       cts,
    input logic       rx_pin,
    input logic       wr_en,
    input logic       txd,
    input logic       buf_empty,
    input logic       tx_done,
    input logic       busy
);
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && mode == MODE_NORMAL) |-> !txd);

    p_wr_fills_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !buf_empty);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (buf_empty && !busy));

    p_cts_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cts && mode != MODE_LOOP) |=> !busy);

    p_break_low_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BREAK && busy) |-> !txd);

    p_echo_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ECHO && !buf_empty) |=> !buf_empty);

    p_echo_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ECHO) |-> (txd == rx_pin));

    p_loop_mark_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOOP) |-> txd);

    p_idle_mark_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode != MODE_ECHO) |-> txd);
endmodule

bind uart_tx_core uart_tx_core_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (line_mode),
    .cts       (cts),
    .rx_pin    (rx_pin),
    .wr_en     (wr_en),
    .txd       (txd),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .busy      (busy)
);

// File: tb/uart_tx_core_bench.sv
`timescale 1ns/1ps
module uart_tx_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_stop = 1'b0;
    logic [2:0] cfg_parity = 3'b110;
    logic [1:0] mode_sel = 2'b00;
    logic       cts = 1'b1;
    logic       rx_pin = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, loop_data, buf_empty, tx_done;

    int checks = 0;
    int fails = 0;
    int tick_every = 1;
    int tdiv = 0;
    int cycles = 0;
    int loop_txd_low = 0;

    always #2.5 clk = ~clk;

    uart_tx_core u_uart_tx_core (
        .clk(clk), .rst(rst), .tick(tick), .cfg_len(cfg_len),
        .cfg_stop(cfg_stop), .cfg_parity(cfg_parity), .mode_sel(mode_sel),
        .cts(cts), .rx_pin(rx_pin), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .loop_data(loop_data), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    // tick divider, changes away from the active edge
    always @(negedge clk) begin
        if (tdiv + 1 >= tick_every) tdiv = 0;
        else tdiv = tdiv + 1;
        tick = (tdiv == 0);
    end

    always @(negedge clk) if (mode_sel == 2'b11 && !txd) loop_txd_low++;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d expected %0d cycles", cycles, 150000);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit line_now(input bit use_loop);
        return use_loop ? loop_data : txd;
    endfunction

    task automatic write_char(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // finds a start bit, samples bit centres, counts negedges from the last
    // sampled centre until tx_done (expected 8 + stop ticks at one tick per clock)
    task automatic capture(input int nd, input bit pe, input bit use_loop,
                           output int dval, output int pval, output int stop_cnt, output bit ok);
        ok = 0; dval = 0; pval = 2; stop_cnt = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!line_now(use_loop)) begin ok = 1; break; end
        end
        if (!ok) return;
        repeat (24) @(negedge clk);
        for (int k = 0; k < nd; k++) begin
            if (k > 0) repeat (16) @(negedge clk);
            dval |= int'(line_now(use_loop)) << k;
        end
        if (pe) begin
            repeat (16) @(negedge clk);
            pval = int'(line_now(use_loop));
        end
        while (!tx_done && stop_cnt < 200) begin
            @(negedge clk);
            stop_cnt++;
        end
    endtask

    // {len, stop, parity, data, expected parity (2 = none), expected stop ticks}
    localparam logic [21:0] VEC [0:7] = '{
        {2'b11, 1'b0, 3'b000, 8'hA5, 2'd0, 6'd16},
        {2'b00, 1'b1, 3'b001, 8'hFF, 2'd0, 6'd24},
        {2'b01, 1'b1, 3'b110, 8'h2D, 2'd2, 6'd32},
        {2'b10, 1'b0, 3'b011, 8'h03, 2'd1, 6'd16},
        {2'b11, 1'b1, 3'b100, 8'h01, 2'd1, 6'd32},
        {2'b00, 1'b0, 3'b101, 8'hE6, 2'd1, 6'd16},
        {2'b01, 1'b0, 3'b010, 8'h07, 2'd1, 6'd16},
        {2'b10, 1'b1, 3'b111, 8'h55, 2'd2, 6'd32}
    };

    initial begin
        int dv, pv, sc, n, bad;
        bit ok;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(txd && buf_empty && tx_done, "R1 reset outputs", {txd, buf_empty, tx_done}, 7);
        rst = 1'b0;
        @(negedge clk);
        check(txd && buf_empty && tx_done, "R1 after reset", {txd, buf_empty, tx_done}, 7);

        // table of frame formats: R2 data, R3 parity, R4 stop length
        for (int v = 0; v < 8; v++) begin
            logic [21:0] e;
            int nd, mask;
            e = VEC[v];
            cfg_len = e[21:20]; cfg_stop = e[19]; cfg_parity = e[18:16];
            nd = 5 + int'(e[21:20]);
            mask = (1 << nd) - 1;
            write_char(e[15:8]);
            capture(nd, e[7:6] != 2'd2, 1'b0, dv, pv, sc, ok);
            check(ok && dv == (int'(e[15:8]) & mask), "R2 data bits", dv, int'(e[15:8]) & mask);
            check(pv == int'(e[7:6]), "R3 parity bit", pv, int'(e[7:6]));
            check(sc == 8 + int'(e[5:0]), "R4 stop length", sc, 8 + int'(e[5:0]));
            check(txd == 1'b1, "R10 idle mark", txd, 1);
        end

        cfg_len = 2'b11; cfg_stop = 1'b0; cfg_parity = 3'b110;

        // R5 buffer flag timing
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h81;
        @(negedge clk); wr_en = 1'b0;
        check(buf_empty == 1'b0, "R5 empty cleared by write", buf_empty, 0);
        check(tx_done == 1'b0, "R5 done low with full buffer", tx_done, 0);
        @(negedge clk);
        check(buf_empty == 1'b1, "R5 empty set on transfer", buf_empty, 1);
        check(tx_done == 1'b0, "R5 done low while shifting", tx_done, 0);
        while (!tx_done) @(negedge clk);

        // R6 cts low holds the character back
        cts = 1'b0;
        write_char(8'h3C);
        bad = 0;
        repeat (50) begin @(negedge clk); if (!txd) bad++; end
        check(bad == 0, "R6 mark while cts low", bad, 0);
        check(buf_empty == 1'b0, "R6 buffer kept while cts low", buf_empty, 0);
        cts = 1'b1;
        capture(8, 1'b0, 1'b0, dv, pv, sc, ok);
        check(ok && dv == 8'h3C, "R6 character after cts high", dv, 8'h3C);

        // R6 cts drop mid-character: full 9*16 + 16 clocks
        write_char(8'h00);
        n = 0;
        for (int i = 0; i < 50 && txd; i++) @(negedge clk);
        while (!tx_done && n < 400) begin
            @(negedge clk); n++;
            if (n == 30) cts = 1'b0;
        end
        check(n == 160, "R6 character completes after cts drop", n, 160);
        cts = 1'b1;

        // R2 start bit lasts 16 ticks at a sparse tick rate
        tick_every = 3;
        write_char(8'hFF);
        for (int i = 0; i < 60 && txd; i++) @(negedge clk);
        n = 0;
        while (!txd && n < 200) begin n++; @(negedge clk); end
        check(n == 48, "R2 start bit 16 ticks", n, 48);
        while (!tx_done) @(negedge clk);
        tick_every = 1;
        repeat (3) @(negedge clk);

        // R7 break: data, and the stop centre read as an extra bit, all 0
        mode_sel = 2'b01;
        write_char(8'hFF);
        capture(8, 1'b1, 1'b0, dv, pv, sc, ok);
        check(ok && dv == 0, "R7 break data bits", dv, 0);
        check(pv == 0, "R7 break stop bit", pv, 0);
        check(txd == 1'b1, "R10 mark after break", txd, 1);
        mode_sel = 2'b00;

        // R8 echo passthrough, buffer untouched
        mode_sel = 2'b10;
        write_char(8'hAA);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); rx_pin = i[0];
            #1 if (txd != rx_pin) bad++;
        end
        check(bad == 0, "R8 echo follows rx_pin", bad, 0);
        check(buf_empty == 1'b0, "R8 buffer kept in echo", buf_empty, 0);
        @(negedge clk); rx_pin = 1'b1; mode_sel = 2'b00;
        capture(8, 1'b0, 1'b0, dv, pv, sc, ok);
        check(ok && dv == 8'hAA, "R8 buffered char sent after echo", dv, 8'hAA);

        // R9 loop mode ignores cts and keeps txd at mark
        mode_sel = 2'b11; cts = 1'b0; loop_txd_low = 0;
        write_char(8'h5A);
        capture(8, 1'b0, 1'b1, dv, pv, sc, ok);
        check(ok && dv == 8'h5A, "R9 loop_data frame", dv, 8'h5A);
        check(loop_txd_low == 0, "R9 txd mark in loop", loop_txd_low, 0);
        check(buf_empty == 1'b1, "R9 buffer drained with cts low", buf_empty, 1);
        mode_sel = 2'b00; cts = 1'b1;

        // R1 reset cuts a frame short
        write_char(8'h00);
        for (int i = 0; i < 50 && txd; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        #1 check(txd && buf_empty && tx_done, "R1 reset mid-frame", {txd, buf_empty, tx_done}, 7);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(txd && buf_empty && tx_done, "R1 idle after mid-frame reset", {txd, buf_empty, tx_done}, 7);

        summary();
    end
endmodule